// File: doc/BRIEF.md
# TDMA Downstream Superframe Generator

This block produces the continuous downstream byte stream that a master node broadcasts to its slave nodes. It emits one byte per byte clock, together with a control-character flag for a downstream 8b/10b encoder. The stream is cut into 4-byte slots, and each slot lasts one trigger period. A superframe opens with a comma character. Then come `NUM_SUB` command subframes: trigger byte, auxiliary byte, command byte 1, command byte 2. A 3-byte closing subframe ends it: trigger byte, auxiliary byte, upstream grant. The closing subframe and the comma fill exactly one slot, so trigger bytes stay exactly 4 bytes apart across superframe boundaries.

The trigger and auxiliary bytes come from the inputs. Subframe n carries the command pair stored for slave n, and a per-slave broadcast flag sets the top bit of command byte 1. The grant byte names the next slave that may use the upstream channel. It is taken from an external address when one is offered, and otherwise from an internal round-robin pointer over the configured number of slaves. Serialization, line coding and optics are outside the block.

Top module: `sfg_downstream_gen`

## Requirements
- R1: While rst_ni is low, byte_o is 0 and k_o is 0. The first byte after reset is released is the comma.
- R2: A superframe is 4*NUM_SUB+4 bytes long. Only its byte 0 is the comma, 8'hBC with k_o=1, and k_o is 0 on every other byte.
- R3: Command subframe n (0 ≤ n < NUM_SUB) occupies superframe bytes 1+4n to 4+4n: trigger, auxiliary, command 1, command 2. Command 2 equals bits [7:0] of table entry n, cmd_table_i[15n+14:15n].
- R4: The trigger byte equals trig_i as sampled on the clock edge that emits it. The auxiliary byte that follows equals aux_i sampled on that same edge, whatever aux_i does afterwards.
- R5: Command 1 of subframe n is {~bcast_i[n], entry n bits [14:8]}: MSB 0 means broadcast and MSB 1 means individually addressed. The entry and the flag are sampled on the edge that emits that subframe's trigger byte.
- R6: The closing subframe occupies bytes 4*NUM_SUB+1 to 4*NUM_SUB+3 (trigger, auxiliary, grant). The trigger spacing stays 4 bytes across the superframe boundary.
- R7: If grant_valid_i is 1 on the edge that emits the grant byte, the grant byte is grant_addr_i zero-extended to 8 bits, and the round-robin pointer keeps its value.
- R8: Otherwise the grant byte is the round-robin pointer, which is 0 after reset. After each such use the pointer becomes 0 if pointer+1 ≥ num_slaves_i (valid range 0..NUM_SUB), and pointer+1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_i | input | 8 | Trigger byte, sampled at slot start |
| aux_i | input | 8 | Auxiliary byte, sampled at slot start |
| cmd_table_i | input | 15*NUM_SUB | Per-slave entries: command 1 payload [14:8], command 2 [7:0] |
| bcast_i | input | NUM_SUB | Per-slave broadcast flag |
| grant_valid_i | input | 1 | External grant address offered |
| grant_addr_i | input | ADDR_W | External grant address |
| num_slaves_i | input | ADDR_W+1 | Number of slaves in the round-robin cycle |
| byte_o | output | 8 | Downstream byte |
| k_o | output | 1 | Control-character flag for the encoder |

## Verification
On every cycle, the assertions check the comma spacing and the comma value, that a trigger byte passes straight through and that the auxiliary byte is held, the mode bit of command 1 against the sampled broadcast flag, that an external grant passes through, and that the round-robin pointer moves. Field placement inside the superframe, the exact round-robin order for each slave count, command 2 contents, and the outputs under reset and mid-stream reset are shown only by the bench's scenarios. The bench compares every output byte against a position-indexed model while all inputs change on every cycle.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  localparam logic [7:0] COMMA_BYTE = 8'hBC;
  localparam int unsigned CMD_W = 15;

  typedef enum logic [1:0] {
    PH_TRIG = 2'd0,
    PH_AUX  = 2'd1,
    PH_CMD1 = 2'd2,
    PH_CMD2 = 2'd3
  } phase_e;
endpackage

// File: rtl/sfg_sequencer.sv
module sfg_sequencer
  import sfg_pkg::*;
#(
  parameter int unsigned NUM_SUB = 64,
  localparam int unsigned SLOT_W = $clog2(NUM_SUB + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output phase_e            phase_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              last_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SUB);

  phase_e            phase_q;
  logic [SLOT_W-1:0] slot_q;

  // reset parks on the comma position of the closing slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD2;
      slot_q  <= LAST_SLOT;
    end else begin
      phase_q <= phase_e'(phase_q + 2'd1);
      if (phase_q == PH_CMD2) begin
        slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;
  assign slot_o  = slot_q;
  assign last_o  = (slot_q == LAST_SLOT);

  AST_SLOT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= LAST_SLOT) else $error("slot out of range"); // R2
endmodule

// File: rtl/sfg_grant_sel.sv
module sfg_grant_sel #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              grant_valid_i,
  input  logic [ADDR_W-1:0] grant_addr_i,
  input  logic [ADDR_W:0]   num_slaves_i,
  output logic [7:0]        grant_byte_o
);
  logic [ADDR_W-1:0] rr_q;
  logic [ADDR_W:0]   rr_inc;

  assign rr_inc = {1'b0, rr_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (take_i && !grant_valid_i) begin
      rr_q <= (rr_inc >= num_slaves_i) ? '0 : rr_inc[ADDR_W-1:0];
    end
  end

  assign grant_byte_o = grant_valid_i ? {{(8-ADDR_W){1'b0}}, grant_addr_i}
                                      : {{(8-ADDR_W){1'b0}}, rr_q};

  AST_RR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !grant_valid_i && num_slaves_i > 1 && {1'b0, rr_q} < num_slaves_i)
    |=> rr_q != $past(rr_q)) else $error("round robin stuck"); // R8
  AST_RR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && grant_valid_i) |=> $stable(rr_q)) else $error("rr moved on external grant"); // R7
endmodule

// File: rtl/sfg_field_mux.sv
module sfg_field_mux
  import sfg_pkg::*;
#(
  parameter int unsigned NUM_SUB = 64,
  localparam int unsigned SLOT_W = $clog2(NUM_SUB + 1),
  localparam int unsigned SUB_W  = $clog2(NUM_SUB)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  phase_e                   phase_i,
  input  logic [SLOT_W-1:0]        slot_i,
  input  logic                     last_i,
  input  logic [7:0]               trig_i,
  input  logic [7:0]               aux_i,
  input  logic [NUM_SUB*CMD_W-1:0] cmd_table_i,
  input  logic [NUM_SUB-1:0]       bcast_i,
  input  logic [7:0]               grant_byte_i,
  output logic [7:0]               byte_o,
  output logic                     k_o
);
  logic [SUB_W-1:0] sub_idx;
  logic [CMD_W-1:0] cmd_sel;
  logic             bcast_sel;
  logic [7:0]       aux_hold_q;
  logic [CMD_W-1:0] cmd_hold_q;
  logic             bc_hold_q;
  logic [7:0]       byte_d;
  logic             k_d;

  assign sub_idx   = slot_i[SUB_W-1:0];
  assign cmd_sel   = cmd_table_i[sub_idx*CMD_W +: CMD_W];
  assign bcast_sel = bcast_i[sub_idx];

  // slot inputs latched on the trigger byte edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aux_hold_q <= '0;
      cmd_hold_q <= '0;
      bc_hold_q  <= 1'b0;
    end else if (phase_i == PH_TRIG) begin
      aux_hold_q <= aux_i;
      if (!last_i) begin
        cmd_hold_q <= cmd_sel;
        bc_hold_q  <= bcast_sel;
      end
    end
  end

  always_comb begin
    byte_d = '0;
    k_d    = 1'b0;
    unique case (phase_i)
      PH_TRIG: byte_d = trig_i;
      PH_AUX:  byte_d = aux_hold_q;
      PH_CMD1: byte_d = last_i ? grant_byte_i : {~bc_hold_q, cmd_hold_q[14:8]};
      PH_CMD2: begin
        if (last_i) begin
          byte_d = COMMA_BYTE;
          k_d    = 1'b1;
        end else begin
          byte_d = cmd_hold_q[7:0];
        end
      end
      default: byte_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o <= '0;
      k_o    <= 1'b0;
    end else begin
      byte_o <= byte_d;
      k_o    <= k_d;
    end
  end

  AST_TRIG_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_TRIG) |=> byte_o == $past(trig_i)) else $error("trigger mismatch"); // R4
  AST_AUX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_TRIG) |=> ##1 byte_o == $past(aux_i, 2)) else $error("aux not held"); // R4
  AST_D1_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_TRIG && !last_i) |=> ##2 byte_o[7] == !$past(bcast_sel, 3)) else $error("mode bit"); // R5
endmodule

// File: rtl/sfg_downstream_gen.sv
module sfg_downstream_gen
  import sfg_pkg::*;
#(
  parameter int unsigned NUM_SUB = 64,
  localparam int unsigned ADDR_W = $clog2(NUM_SUB),
  localparam int unsigned SLOT_W = $clog2(NUM_SUB + 1),
  localparam int unsigned SF_LEN = 4 * NUM_SUB + 4,
  localparam int unsigned IDX_W  = $clog2(SF_LEN)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [7:0]               trig_i,
  input  logic [7:0]               aux_i,
  input  logic [NUM_SUB*CMD_W-1:0] cmd_table_i,
  input  logic [NUM_SUB-1:0]       bcast_i,
  input  logic                     grant_valid_i,
  input  logic [ADDR_W-1:0]        grant_addr_i,
  input  logic [ADDR_W:0]          num_slaves_i,
  output logic [7:0]               byte_o,
  output logic                     k_o
);
  phase_e            phase;
  logic [SLOT_W-1:0] slot;
  logic              last;
  logic              take;
  logic [7:0]        grant_byte;

  sfg_sequencer #(.NUM_SUB(NUM_SUB)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase),
    .slot_o  (slot),
    .last_o  (last)
  );

  assign take = last && (phase == PH_CMD1);

  sfg_grant_sel #(.ADDR_W(ADDR_W)) u_grant (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .take_i        (take),
    .grant_valid_i (grant_valid_i),
    .grant_addr_i  (grant_addr_i),
    .num_slaves_i  (num_slaves_i),
    .grant_byte_o  (grant_byte)
  );

  sfg_field_mux #(.NUM_SUB(NUM_SUB)) u_mux (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .phase_i      (phase),
    .slot_i       (slot),
    .last_i       (last),
    .trig_i       (trig_i),
    .aux_i        (aux_i),
    .cmd_table_i  (cmd_table_i),
    .bcast_i      (bcast_i),
    .grant_byte_i (grant_byte),
    .byte_o       (byte_o),
    .k_o          (k_o)
  );

  // independent byte position tracker for the comma checks
  logic             chk_run_q;
  logic [IDX_W-1:0] chk_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_run_q <= 1'b0;
      chk_idx_q <= '0;
    end else begin
      chk_run_q <= 1'b1;
      if (chk_run_q) begin
        chk_idx_q <= (chk_idx_q == IDX_W'(SF_LEN - 1)) ? '0 : chk_idx_q + 1'b1;
      end
    end
  end

  AST_COMMA_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_run_q |-> (k_o == (chk_idx_q == '0))) else $error("comma spacing"); // R2
  AST_K_IS_COMMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k_o |-> byte_o == COMMA_BYTE) else $error("k flag on non-comma"); // R2
  AST_GRANT_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && grant_valid_i) |=> byte_o == {{(8-ADDR_W){1'b0}}, $past(grant_addr_i)}) else $error("grant"); // R7
endmodule

// File: tb/tb_sfg_downstream_gen.sv
`timescale 1ns/1ps
module tb_sfg_downstream_gen;
  localparam int N      = 4;
  localparam int AW     = 2;
  localparam int CW     = 15;
  localparam int L      = 4 * N + 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [7:0]      trig = '0;
  logic [7:0]      aux = '0;
  logic [N*CW-1:0] cmd_tab = '0;
  logic [N-1:0]    bcast = '0;
  logic            gvalid = 1'b0;
  logic [AW-1:0]   gaddr = '0;
  logic [AW:0]     nslv = '0;
  logic [7:0]      byte_out;
  logic            k_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int idx = 0;
  int rr_m = 0;
  logic [7:0]    aux_m;
  logic [CW-1:0] cmd_m;
  logic          bc_m;

  always #2.5 clk = ~clk;

  sfg_downstream_gen #(.NUM_SUB(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .aux_i(aux),
    .cmd_table_i(cmd_tab), .bcast_i(bcast), .grant_valid_i(gvalid),
    .grant_addr_i(gaddr), .num_slaves_i(nslv), .byte_o(byte_out), .k_o(k_out)
  );

  task automatic chk(string req, logic [7:0] gb, logic gk, logic [7:0] eb, logic ek);
    checks++;
    if (gb !== eb || gk !== ek) begin
      fails++;
      $display("FAIL %s idx=%0d got byte=%h k=%b exp byte=%h k=%b", req, idx, gb, gk, eb, ek);
    end
  endtask

  task automatic drive_random(int gmode);
    trig    = 8'($urandom);
    aux     = 8'($urandom);
    cmd_tab = {N*CW}'({$urandom, $urandom});
    bcast   = N'($urandom);
    gaddr   = AW'($urandom);
    gvalid  = (gmode == 0) ? 1'b0 : 1'($urandom);
  endtask

  // one cycle: check output of previous edge using the inputs it saw
  task automatic step(int gmode);
    int i, p, s;
    logic [7:0] eb;
    logic ek;
    @(negedge clk);
    i = idx % L;
    ek = 1'b0;
    if (i == 0) begin
      eb = 8'hBC; ek = 1'b1;
      chk((idx == 0) ? "R1" : "R2", byte_out, k_out, eb, ek);
    end else begin
      p = (i - 1) % 4;
      s = (i - 1) / 4;
      case (p)
        0: begin
          eb = trig;
          aux_m = aux;
          if (s < N) begin
            cmd_m = cmd_tab[s*CW +: CW];
            bc_m  = bcast[s];
          end
          chk((s == N) ? "R6" : "R4", byte_out, k_out, eb, ek);
        end
        1: begin
          eb = aux_m;
          chk((s == N) ? "R6" : "R4", byte_out, k_out, eb, ek);
        end
        2: begin
          if (s < N) begin
            eb = {~bc_m, cmd_m[14:8]};
            chk("R5", byte_out, k_out, eb, ek);
          end else if (gvalid) begin
            eb = {{(8-AW){1'b0}}, gaddr};
            chk("R7", byte_out, k_out, eb, ek);
          end else begin
            eb = 8'(rr_m);
            chk("R8", byte_out, k_out, eb, ek);
            rr_m = (rr_m + 1 >= int'(nslv)) ? 0 : rr_m + 1;
          end
        end
        default: begin
          eb = cmd_m[7:0];
          chk("R3", byte_out, k_out, eb, ek);
        end
      endcase
    end
    idx++;
    drive_random(gmode);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", byte_out, k_out, 8'h00, 1'b0);
    @(negedge clk);
    chk("R1", byte_out, k_out, 8'h00, 1'b0);
    idx = 0;
    rr_m = 0;
    rst_n = 1'b1;
  endtask

  initial begin
    #40000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    drive_random(0);
    repeat (3) @(negedge clk);
    chk("R1", byte_out, k_out, 8'h00, 1'b0);
    rst_n = 1'b1;
    // R8 sweep: round robin for each slave count
    for (int n = 0; n <= N; n++) begin
      nslv = (AW+1)'(n);
      for (int c = 0; c < 6 * L; c++) step(0);
    end
    // R7 mixed with R8: external grants offered at random
    nslv = (AW+1)'(N - 1);
    for (int c = 0; c < 20 * L; c++) step(1);
    // R1 mid-stream reset, then resume with full count
    do_reset();
    nslv = (AW+1)'(N);
    for (int c = 0; c < 8 * L + 7; c++) step(1);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule